// File: doc/BRIEF.md
# Dual-Channel PCM Codec Serial Port

This block links a 16-bit processor register bus to an external codec that trades 8-bit PCM samples over a serial line. One bit clock, derived from the system clock, is shared by two time slots. Each slot has its own frame-sync pin, so a single data-out line and a single data-in line carry two bidirectional channels. A frame is sixteen bit periods long: first the 8-bit slot of channel A, then the 8-bit slot of channel B.

Software writes a 16-bit linear sample per channel. The transmit path either companders that sample to an 8-bit µ-law code in hardware or sends its low byte unchanged. The choice is made per channel. Received bytes land zero-extended in a per-channel receive register, and a ready flag marks each one. Received codes are not expanded; software does that. The bit clock period is set by a 4-bit prescale value that follows a fixed divide-by-two.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset every register reads zero. While the enable bit (bit 0 at address 0) is clear, serClk, fsChanA, fsChanB and serOut stay low.
- R2: Register map, with three addresses per channel. Channel A uses addresses 0, 1 and 2; channel B uses 3, 4 and 5. At each channel's base address is the control register: bit 1 selects compression, bit 15 is the read-only ready flag, and other bits read zero. Channel A's control register also holds enable in bit 0 and the prescale value in bits 7:4. At base+1 is the 16-bit transmit register, fully readable. At base+2 is the receive register.
- R3: With prescale value P and N = P (or N = 16 when P = 0), serClk is high for N system clocks and low for N, giving a period of 2N.
- R4: A frame is 16 serClk periods. fsChanA is high for exactly one serClk period, the one just before channel A's first bit. fsChanB does the same before channel B's first bit, which directly follows channel A's eighth bit. The two syncs are never high together. After enable, the first frame begins with the fsChanA period.
- R5: serOut sends each slot's byte MSB first and changes only right after a rising serClk edge.
- R6: The byte sent in a slot is taken from the channel's transmit register when the slot starts. If compression is off (bit 1 = 0), it is the register's low 8 bits.
- R7: With compression on, the top 14 bits of the transmit register are read as a two's-complement value v. The sign s is 1 when v < 0. The magnitude |v| is limited to 8158 and then 33 is added, giving b. The segment is e = 0 for b < 64, otherwise the e ≤ 7 with 64·2^(e-1) ≤ b < 64·2^e. The mantissa is m = (b >> (e+1)) & 15. The sent code is the bitwise inverse of {s, e, m}.
- R8: serIn is sampled on each falling serClk edge, MSB first. On the falling edge of a slot's eighth bit, the byte is stored in the receive register, zero-extended to 16 bits.
- R9: A channel's ready flag sets when its received byte is stored and clears when the bus reads that channel's receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (clears ready on receive reads) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr |
| serIn | input | 1 | Serial data from codec |
| serClk | output | 1 | Shared serial bit clock |
| fsChanA | output | 1 | Frame sync, channel A |
| fsChanB | output | 1 | Frame sync, channel B |
| serOut | output | 1 | Serial data to codec |

## Verification
The bench measures the bit-clock period at prescale 1, 3 and 0. A prescaler that treated 0 as a stall or as divide-by-one would show a period other than 32 at 0.

It encodes the µ-law boundary samples: zero, full-scale positive, most-negative, and values near segment edges. A missing bias, a missing clip, or inverted bits would send wrong codes.

A frame-slot error would shift channel B's byte by a bit, or swap it with channel A's, and the serial scoreboard would flag it. Receive checks read the ready flag before and after the receive-register read, which catches a flag that never sets or never clears.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
    logic loadA;
    logic loadB;
    logic doneA;
    logic doneB;
  } strobe_t;
endpackage

// File: rtl/mulaw_enc.sv
module mulaw_enc #(
  parameter int LW = 14
) (
  input  logic [LW-1:0] lin,
  output logic [7:0]    code
);
  localparam int BW   = LW - 1;
  localparam int BIAS = 33;
  localparam int CLIP = 8158;

  logic          sign;
  logic [LW-1:0] mag;
  logic [LW-1:0] clipped;
  logic [BW-1:0] biased;
  logic [2:0]    seg;
  logic [3:0]    mant;

  always_comb begin
    sign    = lin[LW-1];
    mag     = sign ? (~lin + LW'(1)) : lin;
    clipped = (mag > LW'(CLIP)) ? LW'(CLIP) : mag;
    biased  = BW'(clipped + LW'(BIAS));
    seg     = '0;
    for (int i = 5; i < BW; i++)
      if (biased[i]) seg = 3'(i - 5);
    mant = 4'(biased >> (4'(seg) + 4'd1));
    code = ~{sign, seg, mant};
  end
endmodule

// File: rtl/pcm_ctrl.sv
module pcm_ctrl
  import pcm_port_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int SLOT  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PRE_W-1:0] ps,
  output logic             sclk,
  output logic             fsA,
  output logic             fsB,
  output strobe_t          stb
);
  localparam int FRAME = 2 * SLOT;
  localparam int CNT_W = $clog2(FRAME);

  logic [PRE_W-1:0] preCnt, reload;
  logic [CNT_W-1:0] bitCnt, nextBit;
  logic             sclkQ, fsAQ, fsBQ, started, tick;

  always_comb begin
    reload    = '0 - ps;
    tick      = en && (preCnt == '1);
    nextBit   = bitCnt + 1'b1;
    stb.rise  = tick && !sclkQ;
    stb.fall  = tick && sclkQ;
    stb.loadA = stb.rise && (nextBit == '0);
    stb.loadB = stb.rise && (nextBit == CNT_W'(SLOT));
    stb.doneA = stb.fall && started && (bitCnt == CNT_W'(SLOT - 1));
    stb.doneB = stb.fall && started && (bitCnt == CNT_W'(FRAME - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      preCnt  <= reload;
      sclkQ   <= 1'b0;
      bitCnt  <= CNT_W'(FRAME - 2);
      fsAQ    <= 1'b0;
      fsBQ    <= 1'b0;
      started <= 1'b0;
    end else begin
      if (tick) begin
        preCnt <= reload;
        sclkQ  <= ~sclkQ;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
      if (stb.rise) begin
        bitCnt <= nextBit;
        fsAQ   <= (nextBit == CNT_W'(FRAME - 1));
        fsBQ   <= (nextBit == CNT_W'(SLOT - 1));
        if (nextBit == '0) started <= 1'b1;
      end
    end
  end

  assign sclk = sclkQ;
  assign fsA  = fsAQ;
  assign fsB  = fsBQ;

  AST_FS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(fsAQ && fsBQ)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !en |=> (!sclkQ && !fsAQ && !fsBQ)); // R1
endmodule

// File: rtl/pcm_datapath.sv
module pcm_datapath
  import pcm_port_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 3,
  parameter int PRE_W = 4,
  parameter int SLOT  = 8,
  parameter int LW    = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [DW-1:0]    busWdata,
  output logic [DW-1:0]    busRdata,
  input  logic             serIn,
  input  strobe_t          stb,
  output logic             en,
  output logic [PRE_W-1:0] ps,
  output logic             serOut
);
  localparam int NCH = 2;
  localparam int PS_LSB = 4;

  logic             enQ;
  logic [PRE_W-1:0] psQ;
  logic [NCH-1:0]   cmpQ, rdy, doneV;
  logic [DW-1:0]    txQ [NCH];
  logic [SLOT-1:0]  rxQ [NCH];
  logic [SLOT-1:0]  slotByte [NCH];
  logic [7:0]       enc [NCH];
  logic [SLOT-1:0]  txSh, rxSh;

  assign doneV = {stb.doneB, stb.doneA};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mulaw_enc #(.LW(LW)) u_enc (.lin(txQ[c][DW-1 -: LW]), .code(enc[c]));
    assign slotByte[c] = cmpQ[c] ? SLOT'(enc[c]) : txQ[c][SLOT-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ  <= 1'b0;
      psQ  <= '0;
      cmpQ <= '0;
      rdy  <= '0;
      txQ  <= '{default: '0};
      rxQ  <= '{default: '0};
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (busWr && busAddr == AW'(3 * c)) begin
          cmpQ[c] <= busWdata[1];
          if (c == 0) begin
            enQ <= busWdata[0];
            psQ <= busWdata[PS_LSB +: PRE_W];
          end
        end
        if (busWr && busAddr == AW'(3 * c + 1)) txQ[c] <= busWdata;
        if (doneV[c]) begin
          rxQ[c] <= {rxSh[SLOT-2:0], serIn};
          rdy[c] <= 1'b1;
        end else if (busRd && busAddr == AW'(3 * c + 2)) begin
          rdy[c] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enQ) begin
      txSh <= '0;
      rxSh <= '0;
    end else begin
      if (stb.loadA)      txSh <= slotByte[0];
      else if (stb.loadB) txSh <= slotByte[1];
      else if (stb.rise)  txSh <= {txSh[SLOT-2:0], 1'b0};
      if (stb.fall) rxSh <= {rxSh[SLOT-2:0], serIn};
    end
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (busAddr == AW'(3 * c)) begin
        busRdata[DW-1] = rdy[c];
        busRdata[1]    = cmpQ[c];
        if (c == 0) begin
          busRdata[0]               = enQ;
          busRdata[PS_LSB +: PRE_W] = psQ;
        end
      end
      if (busAddr == AW'(3 * c + 1)) busRdata = txQ[c];
      if (busAddr == AW'(3 * c + 2)) busRdata = DW'(rxQ[c]);
    end
  end

  assign en     = enQ;
  assign ps     = psQ;
  assign serOut = txSh[SLOT-1];

  AST_TXD_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    ($past(enQ) && enQ && !$stable(txSh[SLOT-1])) |-> $past(stb.rise)); // R5
  AST_RDY_A_ON_DONE: assert property (@(posedge clk) disable iff (rst) $rose(rdy[0]) |-> $past(stb.doneA)); // R9
  AST_RDY_B_ON_DONE: assert property (@(posedge clk) disable iff (rst) $rose(rdy[1]) |-> $past(stb.doneB)); // R9
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 3,
  parameter int PRE_W = 4,
  parameter int SLOT  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] busAddr,
  input  logic          busWr,
  input  logic          busRd,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  input  logic          serIn,
  output logic          serClk,
  output logic          fsChanA,
  output logic          fsChanB,
  output logic          serOut
);
  strobe_t          stb;
  logic             en;
  logic [PRE_W-1:0] ps;

  pcm_ctrl #(.PRE_W(PRE_W), .SLOT(SLOT)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .ps(ps),
    .sclk(serClk), .fsA(fsChanA), .fsB(fsChanB), .stb(stb)
  );

  pcm_datapath #(.DW(DW), .AW(AW), .PRE_W(PRE_W), .SLOT(SLOT)) u_dp (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .serIn(serIn), .stb(stb),
    .en(en), .ps(ps), .serOut(serOut)
  );
endmodule

// File: tb/pcm_serial_port_bench.sv
module pcm_serial_port_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [15:0] busWdata = '0, busRdata;
  logic        serIn = 1'b0, serClk, fsChanA, fsChanB, serOut;

  int checks = 0, fails = 0;
  int expQ[$];
  bit enShadow = 1'b0;
  bit [7:0] rxPat [2];
  bit finished = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  pcm_serial_port u_pcm_serial_port (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .serIn(serIn), .serClk(serClk),
    .fsChanA(fsChanA), .fsChanB(fsChanB), .serOut(serOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mu(input logic [15:0] x);
    int v, s, mag, seg, mant;
    v = $signed(x);
    v = v >>> 2;
    s = (v < 0) ? 1 : 0;
    mag = s ? -v : v;
    if (mag > 8158) mag = 8158;
    mag += 33;
    seg = 0;
    while (seg < 7 && mag >= (64 << seg)) seg++;
    mant = (mag >> (seg + 1)) & 15;
    return (~((s << 7) | (seg << 4) | mant)) & 8'hFF;
  endfunction

  task automatic writeReg(input int a, input int d);
    @(negedge clk);
    busAddr = 3'(a); busWdata = 16'(d); busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readReg(input int a, output int d);
    @(negedge clk);
    busAddr = 3'(a); busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // Monitor: reassembles serial bytes at the pins and plays codec on serIn
  initial begin : monitor
    bit prev = 1'b0;
    int cnt = 0, pend = 0, cur = 0, e;
    bit [7:0] got = '0;
    forever begin
      @(negedge clk);
      if (!enShadow) begin cnt = 0; pend = 0; end
      if (serClk && !prev) begin
        if (cnt > 0) begin
          got = {got[6:0], serOut}; serIn = rxPat[cur][7-cnt]; cnt++;
        end else if (pend != 0) begin
          cur = pend - 1; got = {7'b0, serOut}; serIn = rxPat[cur][7]; cnt = 1;
        end
        if (cnt == 8) begin
          if (expQ.size() > 0) begin
            e = expQ.pop_front();
            check(got == e[7:0] && cur == e[8],
                  cur == 0 ? "R5/R6/R7 slot A" : "R4/R5/R6/R7 slot B",
                  (cur << 8) | int'(got), e);
          end
          cnt = 0;
        end
        pend = fsChanA ? 1 : (fsChanB ? 2 : 0);
      end
      prev = serClk;
    end
  end

  task automatic runFrames(input int psv, input logic [15:0] txA, input bit cmpA,
                           input logic [15:0] txB, input bit cmpB, input int frames);
    int d, w;
    enShadow = 1'b0;
    writeReg(0, 0);
    writeReg(1, txA);
    writeReg(4, txB);
    writeReg(3, cmpB << 1);
    for (int f = 0; f < frames; f++) begin
      expQ.push_back(cmpA ? mu(txA) : int'(txA[7:0]));
      expQ.push_back(256 | (cmpB ? mu(txB) : int'(txB[7:0])));
    end
    enShadow = 1'b1;
    writeReg(0, (psv << 4) | (cmpA << 1) | 1);
    w = 0;
    while (expQ.size() > 0 && w < 20000) begin @(negedge clk); w++; end
    check(expQ.size() == 0, "R4 all slots seen", expQ.size(), 0);
    repeat (40) @(negedge clk);
    enShadow = 1'b0;
    writeReg(0, psv << 4);
    expQ.delete();
    readReg(0, d); check(d[15] == 1'b1, "R9 ready A set", d[15], 1);
    readReg(2, d); check(d == int'(rxPat[0]), "R8 rx A", d, rxPat[0]);
    readReg(0, d); check(d[15] == 1'b0, "R9 ready A cleared", d[15], 0);
    readReg(3, d); check(d[15] == 1'b1, "R9 ready B set", d[15], 1);
    readReg(5, d); check(d == int'(rxPat[1]), "R8 rx B", d, rxPat[1]);
    readReg(3, d); check(d[15] == 1'b0, "R9 ready B cleared", d[15], 0);
  endtask

  task automatic measure(input int psv);
    int n, hi, per, fw;
    n = (psv == 0) ? 16 : psv;
    writeReg(0, 0);
    writeReg(0, (psv << 4) | 1);
    while (serClk !== 1'b1) @(negedge clk);
    hi = 0; while (serClk === 1'b1) begin @(negedge clk); hi++; end
    per = hi; while (serClk === 1'b0) begin @(negedge clk); per++; end
    check(hi == n, "R3 high time", hi, n);
    check(per == 2 * n, "R3 period", per, 2 * n);
    while (fsChanA !== 1'b1) @(negedge clk);
    fw = 0; while (fsChanA === 1'b1) begin @(negedge clk); fw++; end
    check(fw == 2 * n, "R4 sync width", fw, 2 * n);
    writeReg(0, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin : driver
    int d;
    rxPat[0] = 8'hA5; rxPat[1] = 8'h3C;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 6; a++) begin
      readReg(a, d); check(d == 0, "R1 reset value", d, 0);
    end
    repeat (50) @(negedge clk);
    check({serClk, fsChanA, fsChanB, serOut} == 4'b0, "R1 idle pins",
          {serClk, fsChanA, fsChanB, serOut}, 0);
    writeReg(0, 16'h0036);
    readReg(0, d); check(d == 16'h0032, "R2 ctrl A fields", d, 16'h0032);
    check({serClk, fsChanA} == 2'b0, "R1 disabled stays low", {serClk, fsChanA}, 0);
    writeReg(4, 16'hBEEF);
    readReg(4, d); check(d == 16'hBEEF, "R2 tx B readback", d, 16'hBEEF);
    writeReg(3, 16'h0002);
    readReg(3, d); check(d == 16'h0002, "R2 ctrl B fields", d, 16'h0002);

    measure(3);
    measure(1);
    measure(0);

    runFrames(2, 16'h0000, 1'b1, 16'h1234, 1'b0, 3);
    rxPat[0] = 8'h01; rxPat[1] = 8'hFE;
    runFrames(1, 16'h7FFF, 1'b1, 16'h8000, 1'b1, 3);
    rxPat[0] = 8'h80; rxPat[1] = 8'h7F;
    runFrames(5, 16'hFE70, 1'b1, 16'h0ABC, 1'b1, 2);
    rxPat[0] = 8'h5A; rxPat[1] = 8'hC3;
    runFrames(0, 16'h00A5, 1'b0, 16'h0400, 1'b1, 2);
    runFrames(3, 16'h00FC, 1'b1, 16'hFF04, 1'b1, 2);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule